// File: doc/BRIEF.md
# Write-Once Lock and Reset Gate

This block sits between a decoded host write port (address, data, strobe) and the registers and byte storage of an elapsed-time recorder. It holds two permanent write locks. One guards the timing registers: the alarm threshold, the elapsed-time counter and the event counter. The other guards a ten-byte user memory. Each lock arms only after its own key byte arrives twice in a row at its own address. Once a lock is set, it stays set.

The block turns each host write into a write enable for each region. The enable for a region is held low while that region is locked. The block also holds the three host-writable control bits of the configuration byte: alarm output mode, reset enable and polarity. It returns the full configuration byte for readback, with both lock flags shown as read-only bits.

A reset command reaches the counters and storage only through this block. The block passes the command on as one-cycle clear strobes only when reset is enabled and the timing registers are not locked.

Top module: `wlock_gate`

## Requirements
- R1: While rst_n is low at a clock edge, and after it is released, both lock flags read 0, the writable configuration bits read 0 and all clear strobes are low.
- R2: Two consecutive host writes of byte AAh to address 1Eh set reg_lock. reg_lock reads 1 from the clock edge that takes the second write.
- R3: Two consecutive host writes of byte F0h to address 1Fh set mem_lock. mem_lock reads 1 from the clock edge that takes the second write.
- R4: A host write to any other address, or of any other byte, between the two key writes cancels the partial arming. Cycles with wr_en low do not cancel it. A key written to the other lock's address arms nothing.
- R5: Once set, a lock flag stays 1 through any later write or reset command. Only rst_n returns it to 0.
- R6: reg_wr_en is high in the same cycle as a host write whose address is in 01h..0Ah, but only while reg_lock is 0.
- R7: mem_wr_en is high in the same cycle as a host write whose address is in 0Bh..14h (ten bytes), but only while mem_lock is 0.
- R8: cfg_rdata bits, from bit 7 down to bit 0, are: constant 0, alarm_flag, reg_lock, mem_lock, alarm mode, reset enable, polarity, ecount_msb.
- R9: A host write to address 00h updates only bits 3, 2 and 1 of the configuration byte (mode, reset enable, polarity) from wr_data at the same positions. Those bits change on no other write.
- R10: When rst_cmd is high at a clock edge, reset enable is 1 and reg_lock is 0, the three clear strobes are high for exactly the following cycle.
- R11: While reset enable is 0, rst_cmd raises no clear strobe.
- R12: While reg_lock is 1, rst_cmd raises no clear strobe, whatever reset enable is. mem_lock does not block the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data |
| rst_cmd | input | 1 | Reset command request |
| alarm_flag | input | 1 | Alarm-matched status, shown in readback |
| ecount_msb | input | 1 | Event counter top bit, shown in readback |
| reg_wr_en | output | 1 | Write enable for the timing registers |
| mem_wr_en | output | 1 | Write enable for the user memory |
| reg_lock | output | 1 | Timing-register lock flag |
| mem_lock | output | 1 | User-memory lock flag |
| cfg_rdata | output | 8 | Configuration byte readback |
| alarm_mode | output | 1 | Stored alarm output mode bit |
| alarm_pol | output | 1 | Stored alarm polarity bit |
| clr_elapsed | output | 1 | Clear strobe for the elapsed-time counter |
| clr_store | output | 1 | Clear strobe for stored data |
| clr_events | output | 1 | Clear strobe for the event counter |

## Verification
The bench uses the default parameters: a 5-bit address space, timing registers at 01h..0Ah, user memory at 0Bh..14h and the two key addresses at 1Eh and 1Fh. With this map, both edges of each window can be reached with plain writes, along with the address just past the memory. The default keys let the bench break a partial arming with a wrong byte, with a write elsewhere, and with a key sent to the other lock's address. It also checks that idle cycles leave arming intact.

// File: rtl/wlg_pkg.sv
// Shared constants for the write-once lock and reset gate.
// Assumes an 8-bit configuration byte whose bit positions are decoded by
// the alarm output logic and by host readback software.
package wlg_pkg;
    localparam int BYTE_W  = 8;
    localparam int B_ZERO  = 7;
    localparam int B_ALARM = 6;
    localparam int B_RLOCK = 5;
    localparam int B_MLOCK = 4;
    localparam int B_MODE  = 3;
    localparam int B_RSTEN = 2;
    localparam int B_POL   = 1;
    localparam int B_ECMSB = 0;
    localparam logic [BYTE_W-1:0] CTL_MASK =
        (BYTE_W'(1) << B_MODE) | (BYTE_W'(1) << B_RSTEN) | (BYTE_W'(1) << B_POL);
    localparam int NUM_CLR = 3;
endpackage

// File: rtl/wlg_key_arm.sv
// Key-sequence detector and sticky lock flag.
// Assumes at most one host write per cycle. The lock sets when KEY reaches
// LOCK_ADDR on two back-to-back writes; any other write in between cancels
// the arming. Only rst_n clears the flag.
module wlg_key_arm #(
    parameter int          ADDR_W    = 5,
    parameter int          LOCK_ADDR = 30,
    parameter logic [7:0]  KEY       = 8'hAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              locked
);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_ADDR);

    logic key_hit;
    logic armed_q;
    logic lock_q;

    // Purpose: recognise one key write at this lock's address.
    always_comb key_hit = wr_en && (wr_addr == LOCK_A) && (wr_data == KEY);

    // Purpose: track the first key write and latch the lock on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            lock_q  <= 1'b0;
        end else if (wr_en) begin
            armed_q <= key_hit && !armed_q;
            if (key_hit && armed_q)
                lock_q <= 1'b1;
        end
    end

    assign locked = lock_q;

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    // R2 and R3: lock only follows an armed key write
    lock_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_q) |-> $past(armed_q && key_hit));
endmodule

// File: rtl/wlg_region_gate.sv
// Address window decoder with lock gating for one writable region.
// Assumes the window [BASE, BASE+SPAN) fits in the address space.
module wlg_region_gate #(
    parameter int ADDR_W = 5,
    parameter int BASE   = 1,
    parameter int SPAN   = 10
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              lock,
    output logic              region_we
);
    localparam logic [ADDR_W:0] LO_X = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI_X = (ADDR_W+1)'(BASE + SPAN);

    logic in_window;

    // Purpose: decode the window and suppress writes while locked.
    always_comb begin
        in_window = ({1'b0, wr_addr} >= LO_X) && ({1'b0, wr_addr} < HI_X);
        region_we = wr_en && in_window && !lock;
    end
endmodule

// File: rtl/wlg_cfg_reg.sv
// Holder for the host-writable bits of the configuration byte.
// Assumes the caller decodes the address; only bits in CTL_MASK are kept,
// all other stored positions stay 0.
module wlg_cfg_reg
    import wlg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] ctl_q
);
    // Purpose: load masked control bits on a configuration write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= '0;
        else if (wr_sel)
            ctl_q <= wr_data & CTL_MASK;
    end

    // R9
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(ctl_q));
endmodule

// File: rtl/wlg_reset_gate.sv
// Qualifies the reset command and issues one-cycle clear strobes.
// Assumes each strobe output feeds one storage region; all fire together.
module wlg_reset_gate #(
    parameter int N_OUT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd,
    input  logic             rst_en,
    input  logic             reg_lock,
    output logic [N_OUT-1:0] clr
);
    logic permit;

    // Purpose: allow a clear only when enabled and not register-locked.
    always_comb permit = cmd && rst_en && !reg_lock;

    for (genvar i = 0; i < N_OUT; i++) begin : g_strobe
        // Purpose: register one clear strobe for region i.
        always_ff @(posedge clk) begin
            if (!rst_n)
                clr[i] <= 1'b0;
            else
                clr[i] <= permit;
        end
    end
endmodule

// File: rtl/wlock_gate.sv
// Top of the write-once lock and reset gate.
// Assumes decoded host writes (one per cycle) and that the downstream
// registers honour reg_wr_en / mem_wr_en. Key addresses and windows are
// parameters; defaults give a 5-bit map.
module wlock_gate
    import wlg_pkg::*;
#(
    parameter int         ADDR_W       = 5,
    parameter int         CFG_ADDR     = 0,
    parameter int         REG_BASE     = 1,
    parameter int         REG_SPAN     = 10,
    parameter int         MEM_BASE     = 11,
    parameter int         MEM_SPAN     = 10,
    parameter int         REG_KEY_ADDR = 30,
    parameter logic [7:0] REG_KEY      = 8'hAA,
    parameter int         MEM_KEY_ADDR = 31,
    parameter logic [7:0] MEM_KEY      = 8'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              rst_cmd,
    input  logic              alarm_flag,
    input  logic              ecount_msb,
    output logic              reg_wr_en,
    output logic              mem_wr_en,
    output logic              reg_lock,
    output logic              mem_lock,
    output logic [7:0]        cfg_rdata,
    output logic              alarm_mode,
    output logic              alarm_pol,
    output logic              clr_elapsed,
    output logic              clr_store,
    output logic              clr_events
);
    localparam logic [ADDR_W-1:0] CFG_A = ADDR_W'(CFG_ADDR);

    logic              cfg_sel;
    logic [BYTE_W-1:0] ctl;
    logic [NUM_CLR-1:0] clr_vec;

    // Purpose: select the configuration byte for a host write.
    always_comb cfg_sel = wr_en && (wr_addr == CFG_A);

    wlg_key_arm #(.ADDR_W(ADDR_W), .LOCK_ADDR(REG_KEY_ADDR), .KEY(REG_KEY)) u_reg_arm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(reg_lock));

    wlg_key_arm #(.ADDR_W(ADDR_W), .LOCK_ADDR(MEM_KEY_ADDR), .KEY(MEM_KEY)) u_mem_arm (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .locked(mem_lock));

    wlg_region_gate #(.ADDR_W(ADDR_W), .BASE(REG_BASE), .SPAN(REG_SPAN)) u_reg_win (
        .wr_en(wr_en), .wr_addr(wr_addr), .lock(reg_lock), .region_we(reg_wr_en));

    wlg_region_gate #(.ADDR_W(ADDR_W), .BASE(MEM_BASE), .SPAN(MEM_SPAN)) u_mem_win (
        .wr_en(wr_en), .wr_addr(wr_addr), .lock(mem_lock), .region_we(mem_wr_en));

    wlg_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_sel(cfg_sel), .wr_data(wr_data), .ctl_q(ctl));

    wlg_reset_gate #(.N_OUT(NUM_CLR)) u_rgate (
        .clk(clk), .rst_n(rst_n), .cmd(rst_cmd), .rst_en(ctl[B_RSTEN]),
        .reg_lock(reg_lock), .clr(clr_vec));

    // Purpose: assemble the readback byte from stored and status bits.
    always_comb begin
        cfg_rdata          = ctl;
        cfg_rdata[B_ZERO]  = 1'b0;
        cfg_rdata[B_ALARM] = alarm_flag;
        cfg_rdata[B_RLOCK] = reg_lock;
        cfg_rdata[B_MLOCK] = mem_lock;
        cfg_rdata[B_ECMSB] = ecount_msb;
    end

    assign alarm_mode  = ctl[B_MODE];
    assign alarm_pol   = ctl[B_POL];
    assign clr_elapsed = clr_vec[0];
    assign clr_store   = clr_vec[1];
    assign clr_events  = clr_vec[2];

    // R6
    reg_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lock |-> !reg_wr_en);
    // R7
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_lock |-> !mem_wr_en);
    // R11
    clr_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl[B_RSTEN] |=> !clr_elapsed);
    // R12
    clr_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_lock |=> !(clr_elapsed || clr_store || clr_events));
    // R10
    clr_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_elapsed |-> (clr_store && clr_events));
endmodule

// File: tb/wlock_gate_test.sv
module wlock_gate_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rst_cmd = 1'b0;
    logic       alarm_flag = 1'b0;
    logic       ecount_msb = 1'b0;
    logic       reg_wr_en, mem_wr_en, reg_lock, mem_lock;
    logic [7:0] cfg_rdata;
    logic       alarm_mode, alarm_pol, clr_elapsed, clr_store, clr_events;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wlock_gate uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rst_cmd(rst_cmd), .alarm_flag(alarm_flag), .ecount_msb(ecount_msb),
        .reg_wr_en(reg_wr_en), .mem_wr_en(mem_wr_en), .reg_lock(reg_lock),
        .mem_lock(mem_lock), .cfg_rdata(cfg_rdata), .alarm_mode(alarm_mode),
        .alarm_pol(alarm_pol), .clr_elapsed(clr_elapsed), .clr_store(clr_store),
        .clr_events(clr_events));

    // exp = {reg_lock, mem_lock, reg_wr_en, mem_wr_en} during the write cycle
    typedef struct packed {
        logic       wr;
        logic [4:0] addr;
        logic [7:0] data;
        logic [3:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 5'h01, 8'h11, 4'b0010},  // R6 low edge of register window
        '{1'b1, 5'h0B, 8'h22, 4'b0001},  // R7 low edge of memory
        '{1'b1, 5'h14, 8'h33, 4'b0001},  // R7 high edge of memory
        '{1'b1, 5'h15, 8'h44, 4'b0000},  // R7 just past memory
        '{1'b1, 5'h1E, 8'hAA, 4'b0000},  // R2 arm
        '{1'b1, 5'h1E, 8'h55, 4'b0000},  // R4 wrong byte cancels
        '{1'b1, 5'h1E, 8'hAA, 4'b0000},  // R2 arm
        '{1'b1, 5'h02, 8'h00, 4'b0010},  // R4 other address cancels
        '{1'b1, 5'h1E, 8'hAA, 4'b0000},  // R2 arm
        '{1'b0, 5'h02, 8'hAA, 4'b0000},  // R4 idle keeps arming
        '{1'b1, 5'h1E, 8'hAA, 4'b0000},  // R2 second key, lock follows
        '{1'b1, 5'h03, 8'h66, 4'b1000},  // R6 blocked
        '{1'b1, 5'h0B, 8'h77, 4'b1001},  // R7 memory still open
        '{1'b1, 5'h1F, 8'hF0, 4'b1000},  // R3 arm
        '{1'b1, 5'h1F, 8'hF0, 4'b1000},  // R3 second key
        '{1'b1, 5'h0C, 8'h88, 4'b1100},  // R7 blocked
        '{1'b1, 5'h1E, 8'h00, 4'b1100},  // R5 write to key address
        '{1'b1, 5'h0A, 8'h99, 4'b1100}   // R6 high edge blocked
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // pulse rst_cmd for one edge, then check the strobes in the following cycle
    task automatic pulse_cmd(input string req, input logic [2:0] exp);
        @(negedge clk);
        rst_cmd = 1'b1;
        @(negedge clk);
        rst_cmd = 1'b0;
        #1 check(req, {5'd0, clr_elapsed, clr_store, clr_events}, {5'd0, exp});
        @(negedge clk);
        #1 check({req, " strobe ends"}, {5'd0, clr_elapsed, clr_store, clr_events}, 8'h00);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        alarm_flag = 1'b1; ecount_msb = 1'b1;
        do_reset();
        #1;
        check("R1 R8 reset readback", cfg_rdata, 8'h41);
        check("R1 lock flags", {6'd0, reg_lock, mem_lock}, 8'h00);
        check("R1 clear strobes", {5'd0, clr_elapsed, clr_store, clr_events}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en = VECS[i].wr; wr_addr = VECS[i].addr; wr_data = VECS[i].data;
            #1 check($sformatf("R2/R3/R4/R6/R7 vector %0d", i),
                     {4'd0, reg_lock, mem_lock, reg_wr_en, mem_wr_en}, {4'd0, VECS[i].exp});
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1 check("R8 readback with locks", cfg_rdata, 8'h71);

        pulse_cmd("R11 command with enable low", 3'b000);
        check("R5 locks survive command", {6'd0, reg_lock, mem_lock}, 8'h03);

        do_reset();
        #1 check("R1 reset clears locks", {6'd0, reg_lock, mem_lock}, 8'h00);
        host_write(5'h1F, 8'hAA);
        host_write(5'h1F, 8'hAA);
        host_write(5'h1E, 8'hF0);
        host_write(5'h1E, 8'hF0);
        #1 check("R4 keys swapped arm nothing", {6'd0, reg_lock, mem_lock}, 8'h00);

        alarm_flag = 1'b0; ecount_msb = 1'b0;
        host_write(5'h00, 8'hFF);
        #1 check("R9 only control bits load", cfg_rdata, 8'h0E);
        check("R9 mode and polarity outputs", {6'd0, alarm_mode, alarm_pol}, 8'h03);
        host_write(5'h05, 8'h00);
        #1 check("R9 other address leaves control", cfg_rdata, 8'h0E);
        pulse_cmd("R10 enabled clear", 3'b111);

        host_write(5'h00, 8'hF1);
        #1 check("R9 ignores bits outside control", cfg_rdata, 8'h00);
        pulse_cmd("R11 disabled clear", 3'b000);

        host_write(5'h00, 8'h04);
        host_write(5'h1F, 8'hF0);
        host_write(5'h1F, 8'hF0);
        #1 check("R3 memory lock alone", {6'd0, reg_lock, mem_lock}, 8'h01);
        pulse_cmd("R12 memory lock does not block", 3'b111);
        host_write(5'h1E, 8'hAA);
        host_write(5'h1E, 8'hAA);
        #1 check("R8 R2 readback both locks", cfg_rdata, 8'h34);
        pulse_cmd("R12 register lock blocks clear", 3'b000);
        check("R5 locks held", {6'd0, reg_lock, mem_lock}, 8'h03);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule